// File: doc/BRIEF.md
# Gather Bank-Conflict Arbiter

This block takes one batch of up to eight 32-bit element requests, such as the lanes of a vector gather, and schedules them onto a cache line store. The store is split into sixteen banks, each one word wide. Every bank serves at most one word per cycle. On each cycle the arbiter grants the largest set of pending lanes that it can serve without putting two different words on one bank. Lanes that lose are retried on the next cycle until the whole batch is served.

A requester presents a lane mask and eight byte addresses together with a one-cycle start strobe. The block accepts the strobe only while it is idle. From the next cycle on it drives a per-lane grant vector and a per-bank enable vector, which the line store uses directly. Lanes that ask for the same word share a single bank access. A lane whose address is not word aligned is flagged and never served. A one-cycle done pulse marks the cycle in which the batch finishes.

Top module: `gather_bank_arb`

## Requirements
- R1: The bank of a lane is address bits [5:2]. In every cycle, bit b of `bank_en` is 1 exactly when at least one granted lane maps to bank b.
- R2: If a batch's active, aligned lanes all map to different banks, every one of them is granted in the first cycle after acceptance, and `done` is high in that same cycle.
- R3: In any cycle, no two granted lanes map to the same bank with different word addresses (address bits [31:2]).
- R4: The first pending lane that uses a bank claims that bank for the cycle. A pending lane with a different word on that bank waits for a later cycle. The lowest-numbered pending lane is granted in every busy cycle, so a batch takes at most eight busy cycles.
- R5: Pending lanes with the same word address are granted in the same cycle, together with the lane that claims their bank.
- R6: A lane whose `lane_mask` bit is 0 is never granted and does not block any other lane.
- R7: A lane is misaligned when it is active and its address bits [1:0] are not zero. It raises its `lane_err` bit from the cycle after acceptance until the next acceptance, and it is never granted.
- R8: `done` is high for exactly one cycle, the cycle in which the last pending lane is granted. `busy` is low in the following cycle. A batch with no lane to serve raises `done` with no grant in its first busy cycle.
- R9: A `start` strobe that arrives while `busy` is high is ignored. The grant sequence and `lane_err` of the running batch do not change.
- R10: After reset, `busy`, `done`, `grant`, `bank_en` and `lane_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Batch strobe; taken only when idle |
| lane_mask | input | 8 | Active lanes of the presented batch |
| lane_addr | input | 256 | Byte address of each lane; lane i in bits [32i+31:32i] |
| busy | output | 1 | A batch is being served |
| grant | output | 8 | Lanes served this cycle |
| bank_en | output | 16 | Banks accessed this cycle |
| lane_err | output | 8 | Misaligned active lanes of the latest batch |
| done | output | 1 | Pulse in the cycle of the last grant |

## Verification
In a single cycle, one bank can both merge two lanes that ask for the same word and hold back a third lane that asks for a different word on that bank. The bench provokes this by giving lanes 0 and 2 the same word and giving lane 1 another line on that same bank. It then checks that lanes 0 and 2 are granted together in cycle one, and that lane 1 follows alone in cycle two with `done`. The bench also sends a second start strobe in the middle of a serialized batch, so that an ignored strobe falls in the same cycle as an ongoing grant. It judges the result by checking that the running batch's grant sequence stays the same.

// File: rtl/gba_pkg.sv
// Shared types of the gather bank-conflict arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package gba_pkg;
    typedef enum logic {
        GBA_IDLE = 1'b0,
        GBA_RUN  = 1'b1
    } gba_state_e;
endpackage

// File: rtl/gba_lane_decode.sv
// Splits one lane's byte address into its bank index and word tag.
// Also flags an address that is not aligned to a word.
// Assumes BANKS and WORD_BYTES are powers of two.
module gba_lane_decode #(
    parameter int ADDR_W     = 32,
    parameter int BANKS      = 16,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int BANK_W    = $clog2(BANKS),
    localparam int TAG_W     = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [TAG_W-1:0]  tag,
    output logic              misaligned
);
    // Field extraction: the bank sits just above the byte offset.
    always_comb begin
        bank       = addr[OFF_W +: BANK_W];
        tag        = addr[ADDR_W-1:OFF_W];
        misaligned = |addr[OFF_W-1:0];
    end
endmodule

// File: rtl/gba_pick.sv
// Chooses this cycle's conflict-free subset of pending lanes.
// The lowest pending lane on a bank claims that bank. Other pending lanes
// on the same bank join it only when they ask for the same word.
// Assumes pend is already free of inactive and misaligned lanes.
module gba_pick #(
    parameter int LANES  = 8,
    parameter int BANK_W = 4,
    parameter int TAG_W  = 30
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*BANK_W-1:0] bank_flat,
    input  logic [LANES*TAG_W-1:0]  tag_flat,
    output logic [LANES-1:0]        grant
);
    // Fixed-priority bank claim, with merging of identical words.
    always_comb begin
        logic found;
        logic same_word;
        grant = '0;
        for (int i = 0; i < LANES; i++) begin
            found     = 1'b0;
            same_word = 1'b1;
            for (int j = 0; j < i; j++) begin
                if (!found && pend[j] &&
                    bank_flat[j*BANK_W +: BANK_W] == bank_flat[i*BANK_W +: BANK_W]) begin
                    found     = 1'b1;
                    same_word = (tag_flat[j*TAG_W +: TAG_W] == tag_flat[i*TAG_W +: TAG_W]);
                end
            end
            grant[i] = pend[i] & same_word;
        end
    end
endmodule

// File: rtl/gba_ctrl.sv
// Batch sequencer: takes a batch while idle, then retires granted lanes
// each cycle, and signals done once nothing remains.
// Assumes grant is always a subset of pend.
module gba_ctrl #(
    parameter int LANES = 8,
    localparam int CNT_W = $clog2(LANES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LANES-1:0] load_mask,
    input  logic [LANES-1:0] eligible,
    input  logic [LANES-1:0] grant,
    output logic [LANES-1:0] pend,
    output logic             busy,
    output logic             done,
    output logic             accept
);
    import gba_pkg::*;

    gba_state_e       state_q;
    logic [LANES-1:0] pending_q;
    logic [CNT_W-1:0] run_cnt_q;

    // Status decode from the registered state.
    always_comb begin
        busy   = (state_q == GBA_RUN);
        accept = start && (state_q == GBA_IDLE);
        pend   = busy ? (pending_q & eligible) : '0;
        done   = busy && ((pend & ~grant) == '0);
    end

    // State and pending-lane register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= GBA_IDLE;
            pending_q <= '0;
        end else if (accept) begin
            state_q   <= GBA_RUN;
            pending_q <= load_mask;
        end else if (busy) begin
            pending_q <= pending_q & ~grant;
            if (done) state_q <= GBA_IDLE;
        end
    end

    // Counts busy cycles of the current batch, used only by the bound check.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt_q <= '0;
        else if (accept) run_cnt_q <= '0;
        else if (busy)   run_cnt_q <= run_cnt_q + 1'b1;
    end

    // R4: a batch never needs more than LANES busy cycles.
    a_r4_batch_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt_q < CNT_W'(LANES)));

    // R8: the cycle after done is idle.
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/gather_bank_arb.sv
// Gather bank-conflict arbiter. It latches a batch of lane addresses,
// decodes each lane's bank, and sequences conflict-free grant sets onto
// the bank enables until the batch is served.
// Assumes BANKS is a power of two and that the caller holds start for
// one cycle only while busy is low.
module gather_bank_arb #(
    parameter int LANES      = 8,
    parameter int BANKS      = 16,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int BANK_W    = $clog2(BANKS),
    localparam int TAG_W     = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    output logic                    busy,
    output logic [LANES-1:0]        grant,
    output logic [BANKS-1:0]        bank_en,
    output logic [LANES-1:0]        lane_err,
    output logic                    done
);
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        mask_q;
    logic [LANES*BANK_W-1:0] bank_flat;
    logic [LANES*TAG_W-1:0]  tag_flat;
    logic [LANES-1:0]        mis;
    logic [LANES-1:0]        pend;
    logic                    accept;
    logic                    clash;

    // Batch capture: addresses and mask held for the whole batch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
        end else if (accept) begin
            addr_q <= lane_addr;
            mask_q <= lane_mask;
        end
    end

    // One decoder per lane on the captured addresses.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        gba_lane_decode #(
            .ADDR_W(ADDR_W), .BANKS(BANKS), .WORD_BYTES(WORD_BYTES)
        ) u_dec (
            .addr       (addr_q[g*ADDR_W +: ADDR_W]),
            .bank       (bank_flat[g*BANK_W +: BANK_W]),
            .tag        (tag_flat[g*TAG_W +: TAG_W]),
            .misaligned (mis[g])
        );
    end

    gba_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_mask (lane_mask),
        .eligible  (~mis),
        .grant     (grant),
        .pend      (pend),
        .busy      (busy),
        .done      (done),
        .accept    (accept)
    );

    gba_pick #(.LANES(LANES), .BANK_W(BANK_W), .TAG_W(TAG_W)) u_pick (
        .pend      (pend),
        .bank_flat (bank_flat),
        .tag_flat  (tag_flat),
        .grant     (grant)
    );

    // Error flags of the captured batch.
    always_comb lane_err = mask_q & mis;

    // Bank enables gathered from the granted lanes.
    always_comb begin
        bank_en = '0;
        for (int i = 0; i < LANES; i++)
            if (grant[i]) bank_en[bank_flat[i*BANK_W +: BANK_W]] = 1'b1;
    end

    // Check-only: detects two granted lanes with different words on one bank.
    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < LANES; i++)
            for (int j = i + 1; j < LANES; j++)
                if (grant[i] && grant[j] &&
                    bank_flat[i*BANK_W +: BANK_W] == bank_flat[j*BANK_W +: BANK_W] &&
                    tag_flat[i*TAG_W +: TAG_W] != tag_flat[j*TAG_W +: TAG_W])
                    clash = 1'b1;
    end

    // R3: no bank carries two different words in one cycle.
    a_r3_no_bank_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !clash);

    // R4: the lowest pending lane always makes progress.
    a_r4_lowest_served: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> ((grant & pend & (~pend + 1'b1)) != '0));

    // R6: only pending lanes of the captured batch are granted.
    a_r6_grant_in_batch: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~mask_q) == '0);

    // R7: flagged lanes are never served.
    a_r7_err_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & lane_err) == '0);

    // R9: a strobe during a batch leaves the captured mask untouched.
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mask_q));
endmodule

// File: tb/gather_bank_arb_test.sv
// Directed bench for the gather bank-conflict arbiter.
module gather_bank_arb_test;
    localparam int CLK_PERIOD = 10;
    localparam int L = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [L-1:0]    lane_mask = '0;
    logic [L*32-1:0] lane_addr = '0;
    logic            busy;
    logic [L-1:0]    grant;
    logic [15:0]     bank_en;
    logic [L-1:0]    lane_err;
    logic            done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] ta [L];

    gather_bank_arb uut (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_mask(lane_mask),
        .lane_addr(lane_addr), .busy(busy), .grant(grant), .bank_en(bank_en),
        .lane_err(lane_err), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] bk(input logic [31:0] a);
        return a[5:2];
    endfunction

    // Model: per bank, the first remaining lane owns it; same-word lanes join.
    task automatic model(input logic [L-1:0] rem, output logic [L-1:0] eg,
                         output logic [15:0] eb);
        eg = '0;
        eb = '0;
        for (int b = 0; b < 16; b++) begin
            int owner = -1;
            for (int i = 0; i < L; i++)
                if (owner < 0 && rem[i] && bk(ta[i]) == 4'(b)) owner = i;
            if (owner >= 0) begin
                eb[b] = 1'b1;
                for (int i = 0; i < L; i++)
                    if (rem[i] && bk(ta[i]) == 4'(b) && ta[i][31:2] == ta[owner][31:2])
                        eg[i] = 1'b1;
            end
        end
    endtask

    // Runs one batch from ta/mask, checking every cycle; optional poke cycle.
    task automatic run_batch(input string tag, input logic [L-1:0] mask,
                             input int exp_cycles, input int poke_cycle);
        logic [L-1:0] rem, eg, eerr;
        logic [15:0]  eb;
        int cyc;
        @(negedge clk);
        for (int i = 0; i < L; i++) lane_addr[i*32 +: 32] = ta[i];
        lane_mask = mask;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        eerr = '0;
        for (int i = 0; i < L; i++) eerr[i] = mask[i] && (ta[i][1:0] != 2'b00);
        rem = mask & ~eerr;
        cyc = 0;
        while (1) begin
            cyc++;
            model(rem, eg, eb);
            chk({tag, " busy"}, 32'(busy), 32'd1);
            chk({tag, " grant"}, 32'(grant), 32'(eg));
            chk({tag, " bank_en R1"}, 32'(bank_en), 32'(eb));
            chk({tag, " done R8"}, 32'(done), 32'((rem & ~eg) == '0));
            chk({tag, " lane_err R7"}, 32'(lane_err), 32'(eerr));
            if (cyc == poke_cycle) begin
                start = 1'b1;
                lane_mask = 8'hFF;
                lane_addr = '0;
            end
            rem = rem & ~eg;
            if (rem == '0) break;
            if (cyc >= 8) begin
                chk({tag, " R4 batch exceeds 8 cycles"}, 32'(cyc), 32'd8);
                break;
            end
            @(negedge clk);
            start = 1'b0;
        end
        if (exp_cycles > 0) chk({tag, " cycles R4"}, 32'(cyc), 32'(exp_cycles));
        @(negedge clk);
        start = 1'b0;
        chk({tag, " idle after R8"}, 32'(busy), 32'd0);
        chk({tag, " no done after R8"}, 32'(done), 32'd0);
        chk({tag, " no grant idle R8"}, 32'(grant), 32'd0);
        chk({tag, " err held R7"}, 32'(lane_err), 32'(eerr));
    endtask

    task automatic t_reset;
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 done", 32'(done), 32'd0);
        chk("R10 grant", 32'(grant), 32'd0);
        chk("R10 bank_en", 32'(bank_en), 32'd0);
        chk("R10 lane_err", 32'(lane_err), 32'd0);
    endtask

    task automatic t_distinct;
        int bnk [L] = '{3, 0, 15, 7, 1, 9, 12, 4};
        for (int i = 0; i < L; i++) ta[i] = 32'h1000 + 32'(i*64*3) + 32'(bnk[i]*4);
        run_batch("R2 distinct banks", 8'hFF, 1, -1);
    endtask

    task automatic t_same_bank;
        for (int i = 0; i < L; i++) ta[i] = 32'h2000 + 32'(i*64) + 32'd24;
        run_batch("R4 one bank eight lines", 8'hFF, 8, -1);
        run_batch("R9 start while busy", 8'hFF, 8, 2);
    endtask

    task automatic t_merge;
        for (int i = 0; i < L; i++) ta[i] = 32'h3014;
        run_batch("R5 all same word", 8'hFF, 1, -1);
        for (int i = 0; i < L; i++) ta[i] = 32'h4000 + 32'(i*4);
        ta[0] = 32'h5014; ta[1] = 32'h5054; ta[2] = 32'h5014;
        run_batch("R3 R5 merge with conflict", 8'h07, 2, -1);
    endtask

    task automatic t_mask;
        for (int i = 0; i < L; i++) ta[i] = 32'h6000 + 32'(i*64) + 32'(i*4);
        ta[1] = 32'h7000; ta[3] = 32'h7008; ta[4] = 32'h7104; ta[6] = 32'h7114;
        run_batch("R6 masked lanes", 8'b1010_0101, 1, -1);
    endtask

    task automatic t_misalign;
        for (int i = 0; i < L; i++) ta[i] = 32'h8000 + 32'(i*4);
        ta[3] = 32'h8001; ta[5] = 32'h8016;
        ta[6] = 32'h8043;
        run_batch("R7 misaligned", 8'hBF, 1, -1);
        for (int i = 0; i < L; i++) ta[i] = 32'h9002 + 32'(i*4);
        run_batch("R7 R8 all misaligned", 8'hFF, 1, -1);
    endtask

    task automatic t_empty;
        for (int i = 0; i < L; i++) ta[i] = 32'hA000;
        run_batch("R8 empty batch", 8'h00, 1, -1);
    endtask

    task automatic t_mixed;
        for (int k = 1; k <= 6; k++) begin
            for (int i = 0; i < L; i++)
                ta[i] = 32'hB000 + 32'(((i*7 + k) % 3) * 64) + 32'(((i*k) % 5) * 4);
            run_batch("R3 mixed pattern", 8'(8'hFF >> (k % 3)), -1, -1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_distinct();
        t_same_bank();
        t_merge();
        t_mask();
        t_misalign();
        t_empty();
        t_mixed();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule